// File: doc/BRIEF.md
# CPU Exception Entry Sequencer

This block decides, each clock cycle, whether the processor core enters an exception handler, enters an interrupt handler, or asks for a system reset. It then performs the entry in one step. The core presents a pending exception code, an interrupt request, and its current status word, program counter, stack register, vector base and delay-slot flag. An external interrupt priority controller answers with a vector, or with no vector at all, for the interrupt mask that this block drives out.

On entry the block saves the old status word, the return address and the stack register into their shadow registers. It records the cause and computes the handler address from the vector base. Four classes of cause use different targets: reset-class, translation-miss, general, and interrupt. A taken entry gives a one-cycle `taken` pulse. The core uses that pulse to leave sleep and to drop its load-locked reservation. A separate `dsClear` pulse tells the core to clear its delay-slot flag.

Status bits used: 28 = block, 29 = register bank, 30 = privileged mode, 15 = FPU disable, and [7:4] = interrupt mask. Outputs are registered and change at the clock edge that samples the request.

Top module: `exc_entry_top`

## Requirements
- R1: When `excValid` and `irqReq` are both high in a cycle, only the exception is handled: `expevtOut` takes the code, `intevtOut` is unchanged, and `pcOut` takes the exception target.
- R2: If status bit 28 is set and `excValid` carries any code other than 0x1E0, `resetReq` pulses for one cycle, `taken` stays low, and every saved register and `pcOut` keep their values.
- R3: If status bit 28 is set, an exception with code 0x1E0 is entered normally at `vbrIn`+0x100.
- R4: If status bit 28 is set, an interrupt is ignored unless `sleeping` is high. When `sleeping` is high, the interrupt is entered.
- R5: On any entry, `ssrOut` takes `srIn` and `sgrOut` takes `r15In`. `srOut` is `srIn` with bits 28, 29 and 30 set.
- R6: An entry taken while `delaySlot` is high gives `spcOut` = `pcIn`−2 and a one-cycle `dsClear` pulse. Without the delay slot, `spcOut` = `pcIn` and `dsClear` stays low.
- R7: Exception codes 0x000, 0x020 and 0x140 clear status bit 15, set bits [7:4] to 0xF, and give `pcOut` = 0xA0000000.
- R8: Codes 0x040 and 0x060 give `pcOut` = `vbrIn`+0x400. Every other exception code gives `vbrIn`+0x100. `expevtOut` takes the code on every exception entry.
- R9: Code 0x160 adds 2 to `spcOut`, on top of any delay-slot adjustment.
- R10: `irqMask` equals `srIn`[7:4]. An accepted interrupt with `irqVecValid` high loads `intevtOut` with `irqVec` and `pcOut` with `vbrIn`+0x600. With `irqVecValid` low, nothing changes.
- R11: An interrupt request is not accepted while `delaySlot` is high.
- R12: `taken` is a single-cycle pulse in the cycle after the request. In cycles with no entry the saved registers hold. Reset gives `srOut` = 0x700000F0, `pcOut` = 0xA0000000, all other outputs zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| excValid | input | 1 | An exception is pending this cycle |
| excCode | input | 12 | Code of the pending exception |
| irqReq | input | 1 | Hardware interrupt request |
| irqVecValid | input | 1 | Priority controller returns a vector |
| irqVec | input | 12 | Vector from the priority controller |
| irqMask | output | 4 | Current interrupt mask passed to the controller |
| srIn | input | 32 | Current status word |
| pcIn | input | 32 | Current program counter |
| r15In | input | 32 | Current stack register |
| vbrIn | input | 32 | Vector base |
| delaySlot | input | 1 | A delay-slot instruction is in progress |
| sleeping | input | 1 | Core is in sleep |
| taken | output | 1 | Entry performed (one-cycle pulse) |
| resetReq | output | 1 | Blocked exception requests a reset |
| dsClear | output | 1 | Clear the delay-slot flag |
| srOut | output | 32 | Updated status word |
| ssrOut | output | 32 | Saved status word |
| spcOut | output | 32 | Saved return address |
| sgrOut | output | 32 | Saved stack register |
| expevtOut | output | 12 | Last exception code |
| intevtOut | output | 12 | Last interrupt vector |
| pcOut | output | 32 | Handler address |

## Verification
The properties assume that the core holds a request for exactly one cycle, since a request held longer is a new entry each cycle. They also assume that `irqVecValid` already reflects the mask on `irqMask` in the same cycle, because the controller is combinational from the block's point of view. The bench drives each request as a one-cycle pulse followed by an idle cycle. It chooses `irqVecValid` directly as a free input, so every accept and decline path is reached without modelling the controller.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  // Status word bit positions the entry logic reads and writes
  localparam int SR_FD = 15;
  localparam int SR_BL = 28;
  localparam int SR_RB = 29;
  localparam int SR_MD = 30;
  localparam int SR_IM_LO = 4;
  localparam int IM_W = 4;

  typedef enum logic [1:0] {
    VEC_RESET,
    VEC_TLB,
    VEC_GEN,
    VEC_IRQ
  } vecSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic    load;
    logic    isExc;
    logic    rstReq;
    vecSel_e vecSel;
    logic    dsAdj;
    logic    trapaAdj;
  } strobe_t;
endpackage

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int EVT_W = 12
) (
  input  logic             excValid,
  input  logic [EVT_W-1:0] excCode,
  input  logic             irqReq,
  input  logic             irqVecValid,
  input  logic             srBl,
  input  logic             sleeping,
  input  logic             delaySlot,
  output strobe_t          strb
);
  localparam logic [EVT_W-1:0] CODE_PWR   = EVT_W'('h000);
  localparam logic [EVT_W-1:0] CODE_MAN   = EVT_W'('h020);
  localparam logic [EVT_W-1:0] CODE_MULT  = EVT_W'('h140);
  localparam logic [EVT_W-1:0] CODE_RMISS = EVT_W'('h040);
  localparam logic [EVT_W-1:0] CODE_WMISS = EVT_W'('h060);
  localparam logic [EVT_W-1:0] CODE_TRAP  = EVT_W'('h160);
  localparam logic [EVT_W-1:0] CODE_BLOK  = EVT_W'('h1E0);

  logic excBlocked;
  logic irqAccept;

  assign excBlocked = srBl && (excCode != CODE_BLOK);
  assign irqAccept  = irqReq && !delaySlot && (!srBl || sleeping) && irqVecValid;

  always_comb begin
    strb = '0;
    strb.vecSel = VEC_GEN;
    if (excValid) begin
      if (excBlocked) begin
        strb.rstReq = 1'b1;
      end else begin
        strb.load  = 1'b1;
        strb.isExc = 1'b1;
        strb.dsAdj = delaySlot;
        unique case (excCode)
          CODE_PWR, CODE_MAN, CODE_MULT: strb.vecSel = VEC_RESET;
          CODE_RMISS, CODE_WMISS:        strb.vecSel = VEC_TLB;
          CODE_TRAP: begin
            strb.vecSel   = VEC_GEN;
            strb.trapaAdj = 1'b1;
          end
          default:                       strb.vecSel = VEC_GEN;
        endcase
      end
    end else if (irqAccept) begin
      strb.load   = 1'b1;
      strb.vecSel = VEC_IRQ;
    end
  end
endmodule

// File: rtl/exc_entry_dp.sv
module exc_entry_dp
  import exc_entry_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int EVT_W = 12,
  parameter logic [DATA_W-1:0] RESET_PC = 'hA000_0000,
  parameter logic [DATA_W-1:0] TLB_OFF = 'h400,
  parameter logic [DATA_W-1:0] GEN_OFF = 'h100,
  parameter logic [DATA_W-1:0] IRQ_OFF = 'h600
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [EVT_W-1:0]  excCode,
  input  logic [EVT_W-1:0]  irqVec,
  input  logic [DATA_W-1:0] srIn,
  input  logic [DATA_W-1:0] pcIn,
  input  logic [DATA_W-1:0] r15In,
  input  logic [DATA_W-1:0] vbrIn,
  output logic              taken,
  output logic              resetReq,
  output logic              dsClear,
  output logic [DATA_W-1:0] srOut,
  output logic [DATA_W-1:0] ssrOut,
  output logic [DATA_W-1:0] spcOut,
  output logic [DATA_W-1:0] sgrOut,
  output logic [EVT_W-1:0]  expevtOut,
  output logic [EVT_W-1:0]  intevtOut,
  output logic [DATA_W-1:0] pcOut
);
  localparam logic [DATA_W-1:0] ENTRY_SET =
    (DATA_W'(1) << SR_BL) | (DATA_W'(1) << SR_RB) | (DATA_W'(1) << SR_MD);
  localparam logic [DATA_W-1:0] IM_FIELD = DATA_W'(((1 << IM_W) - 1) << SR_IM_LO);
  localparam logic [DATA_W-1:0] SR_RESET = ENTRY_SET | IM_FIELD;
  localparam logic [DATA_W-1:0] TWO = DATA_W'(2);

  logic [DATA_W-1:0] srNext;
  logic [DATA_W-1:0] pcNext;
  logic [DATA_W-1:0] spcNext;

  always_comb begin
    srNext = srIn | ENTRY_SET;
    if (strb.vecSel == VEC_RESET) begin
      srNext[SR_FD] = 1'b0;
      srNext = srNext | IM_FIELD;
    end
  end

  always_comb begin
    unique case (strb.vecSel)
      VEC_RESET: pcNext = RESET_PC;
      VEC_TLB:   pcNext = vbrIn + TLB_OFF;
      VEC_GEN:   pcNext = vbrIn + GEN_OFF;
      default:   pcNext = vbrIn + IRQ_OFF;
    endcase
  end

  always_comb begin
    spcNext = pcIn;
    if (strb.dsAdj) spcNext = spcNext - TWO;
    if (strb.trapaAdj) spcNext = spcNext + TWO;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      taken     <= 1'b0;
      resetReq  <= 1'b0;
      dsClear   <= 1'b0;
      srOut     <= SR_RESET;
      ssrOut    <= '0;
      spcOut    <= '0;
      sgrOut    <= '0;
      expevtOut <= '0;
      intevtOut <= '0;
      pcOut     <= RESET_PC;
    end else begin
      taken    <= strb.load;
      resetReq <= strb.rstReq;
      dsClear  <= strb.load && strb.dsAdj;
      if (strb.load) begin
        srOut  <= srNext;
        ssrOut <= srIn;
        spcOut <= spcNext;
        sgrOut <= r15In;
        pcOut  <= pcNext;
        if (strb.isExc) expevtOut <= excCode;
        else            intevtOut <= irqVec;
      end
    end
  end
endmodule

// File: rtl/exc_entry_top.sv
module exc_entry_top
  import exc_entry_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int EVT_W = 12,
  parameter logic [DATA_W-1:0] RESET_PC = 'hA000_0000,
  parameter logic [DATA_W-1:0] TLB_OFF = 'h400,
  parameter logic [DATA_W-1:0] GEN_OFF = 'h100,
  parameter logic [DATA_W-1:0] IRQ_OFF = 'h600
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              excValid,
  input  logic [EVT_W-1:0]  excCode,
  input  logic              irqReq,
  input  logic              irqVecValid,
  input  logic [EVT_W-1:0]  irqVec,
  output logic [IM_W-1:0]   irqMask,
  input  logic [DATA_W-1:0] srIn,
  input  logic [DATA_W-1:0] pcIn,
  input  logic [DATA_W-1:0] r15In,
  input  logic [DATA_W-1:0] vbrIn,
  input  logic              delaySlot,
  input  logic              sleeping,
  output logic              taken,
  output logic              resetReq,
  output logic              dsClear,
  output logic [DATA_W-1:0] srOut,
  output logic [DATA_W-1:0] ssrOut,
  output logic [DATA_W-1:0] spcOut,
  output logic [DATA_W-1:0] sgrOut,
  output logic [EVT_W-1:0]  expevtOut,
  output logic [EVT_W-1:0]  intevtOut,
  output logic [DATA_W-1:0] pcOut
);
  strobe_t strb;

  assign irqMask = srIn[SR_IM_LO +: IM_W];

  exc_entry_ctrl #(.EVT_W(EVT_W)) u_ctrl (
    .excValid   (excValid),
    .excCode    (excCode),
    .irqReq     (irqReq),
    .irqVecValid(irqVecValid),
    .srBl       (srIn[SR_BL]),
    .sleeping   (sleeping),
    .delaySlot  (delaySlot),
    .strb       (strb)
  );

  exc_entry_dp #(
    .DATA_W(DATA_W), .EVT_W(EVT_W), .RESET_PC(RESET_PC),
    .TLB_OFF(TLB_OFF), .GEN_OFF(GEN_OFF), .IRQ_OFF(IRQ_OFF)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .excCode  (excCode),
    .irqVec   (irqVec),
    .srIn     (srIn),
    .pcIn     (pcIn),
    .r15In    (r15In),
    .vbrIn    (vbrIn),
    .taken    (taken),
    .resetReq (resetReq),
    .dsClear  (dsClear),
    .srOut    (srOut),
    .ssrOut   (ssrOut),
    .spcOut   (spcOut),
    .sgrOut   (sgrOut),
    .expevtOut(expevtOut),
    .intevtOut(intevtOut),
    .pcOut    (pcOut)
  );
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int DATA_W = 32,
  parameter int EVT_W = 12,
  parameter logic [DATA_W-1:0] IRQ_OFF = 'h600
) (
  input logic              clk,
  input logic              rstN,
  input logic              excValid,
  input logic [EVT_W-1:0]  excCode,
  input logic              irqReq,
  input logic              irqVecValid,
  input logic [EVT_W-1:0]  irqVec,
  input logic              srBl,
  input logic [DATA_W-1:0] vbrIn,
  input logic              delaySlot,
  input logic              sleeping,
  input logic              taken,
  input logic              resetReq,
  input logic [2:0]        srTop,
  input logic [DATA_W-1:0] ssrOut,
  input logic [EVT_W-1:0]  expevtOut,
  input logic [EVT_W-1:0]  intevtOut,
  input logic [DATA_W-1:0] pcOut
);
  localparam logic [EVT_W-1:0] CODE_BLOK = EVT_W'('h1E0);

  assert_one_outcome_R12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({taken, resetReq}));

  assert_blocked_reset_R2: assert property (@(posedge clk) disable iff (!rstN)
    (excValid && srBl && excCode != CODE_BLOK) |=> (resetReq && !taken));

  assert_exc_wins_R1: assert property (@(posedge clk) disable iff (!rstN)
    (excValid && !(srBl && excCode != CODE_BLOK))
      |=> (taken && expevtOut == $past(excCode) && $stable(intevtOut)));

  assert_ds_blocks_irq_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!excValid && irqReq && delaySlot) |=> !taken);

  assert_entry_bits_R5: assert property (@(posedge clk) disable iff (!rstN)
    taken |-> (srTop == 3'b111));

  assert_hold_idle_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!excValid && !irqReq) |=> (!taken && $stable(ssrOut) && $stable(pcOut)));

  assert_irq_entry_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!excValid && irqReq && !delaySlot && irqVecValid && (!srBl || sleeping))
      |=> (taken && intevtOut == $past(irqVec) && pcOut == $past(vbrIn) + IRQ_OFF));

  assert_blocked_irq_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!excValid && irqReq && srBl && !sleeping) |=> !taken);
endmodule

bind exc_entry_top exc_entry_chk #(
  .DATA_W(DATA_W), .EVT_W(EVT_W), .IRQ_OFF(IRQ_OFF)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .excValid   (excValid),
  .excCode    (excCode),
  .irqReq     (irqReq),
  .irqVecValid(irqVecValid),
  .irqVec     (irqVec),
  .srBl       (srIn[28]),
  .vbrIn      (vbrIn),
  .delaySlot  (delaySlot),
  .sleeping   (sleeping),
  .taken      (taken),
  .resetReq   (resetReq),
  .srTop      (srOut[30:28]),
  .ssrOut     (ssrOut),
  .expevtOut  (expevtOut),
  .intevtOut  (intevtOut),
  .pcOut      (pcOut)
);

// File: tb/sim_exc_entry_top.sv
`timescale 1ns/1ps
module sim_exc_entry_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        excValid = 1'b0;
  logic [11:0] excCode = '0;
  logic        irqReq = 1'b0;
  logic        irqVecValid = 1'b0;
  logic [11:0] irqVec = '0;
  logic [3:0]  irqMask;
  logic [31:0] srIn = '0, pcIn = '0, r15In = '0, vbrIn = '0;
  logic        delaySlot = 1'b0, sleeping = 1'b0;
  logic        taken, resetReq, dsClear;
  logic [31:0] srOut, ssrOut, spcOut, sgrOut, pcOut;
  logic [11:0] expevtOut, intevtOut;

  int nTests = 0;
  int nFail = 0;
  bit finished = 0;

  // expected architectural state
  logic [31:0] eSr = 32'h7000_00F0, eSsr = '0, eSpc = '0, eSgr = '0, ePc = 32'hA000_0000;
  logic [11:0] eExp = '0, eInt = '0;

  always #4 clk = ~clk;

  exc_entry_top u0 (
    .clk(clk), .rstN(rstN), .excValid(excValid), .excCode(excCode),
    .irqReq(irqReq), .irqVecValid(irqVecValid), .irqVec(irqVec), .irqMask(irqMask),
    .srIn(srIn), .pcIn(pcIn), .r15In(r15In), .vbrIn(vbrIn),
    .delaySlot(delaySlot), .sleeping(sleeping), .taken(taken), .resetReq(resetReq),
    .dsClear(dsClear), .srOut(srOut), .ssrOut(ssrOut), .spcOut(spcOut),
    .sgrOut(sgrOut), .expevtOut(expevtOut), .intevtOut(intevtOut), .pcOut(pcOut)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic checkState(input string tag, input logic eTaken, input logic eRst,
                            input logic eDs);
    chk(tag, "taken", {31'b0, taken}, {31'b0, eTaken});
    chk(tag, "resetReq", {31'b0, resetReq}, {31'b0, eRst});
    chk(tag, "dsClear", {31'b0, dsClear}, {31'b0, eDs});
    chk(tag, "srOut", srOut, eSr);
    chk("R5", "ssrOut", ssrOut, eSsr);
    chk("R5", "sgrOut", sgrOut, eSgr);
    chk(tag, "spcOut", spcOut, eSpc);
    chk(tag, "pcOut", pcOut, ePc);
    chk(tag, "expevtOut", {20'b0, expevtOut}, {20'b0, eExp});
    chk(tag, "intevtOut", {20'b0, intevtOut}, {20'b0, eInt});
  endtask

  // one request cycle, one idle cycle; model computed from the requirements
  task automatic request(input logic ex, input logic [11:0] code, input logic irq,
                         input logic vv, input logic [11:0] vec, input logic [31:0] sr,
                         input logic [31:0] pc, input logic [31:0] r15,
                         input logic [31:0] vbr, input logic ds, input logic slp,
                         input string forceTag);
    logic bl;
    logic eTaken, eRst, eDs;
    string tag;
    bl = sr[28];
    eTaken = 1'b0; eRst = 1'b0; eDs = 1'b0;
    tag = forceTag;
    @(negedge clk);
    excValid = ex; excCode = code; irqReq = irq; irqVecValid = vv; irqVec = vec;
    srIn = sr; pcIn = pc; r15In = r15; vbrIn = vbr; delaySlot = ds; sleeping = slp;
    #1;
    chk("R10", "irqMask", {28'b0, irqMask}, {28'b0, sr[7:4]});
    if (ex) begin
      if (bl && code != 12'h1E0) begin
        eRst = 1'b1;
        if (tag == "") tag = "R2";
      end else begin
        eTaken = 1'b1; eDs = ds;
        eSsr = sr; eSgr = r15; eExp = code;
        eSpc = pc - (ds ? 32'd2 : 32'd0) + (code == 12'h160 ? 32'd2 : 32'd0);
        eSr = sr | 32'h7000_0000;
        if (code == 12'h000 || code == 12'h020 || code == 12'h140) begin
          eSr[15] = 1'b0; eSr[7:4] = 4'hF; ePc = 32'hA000_0000;
          if (tag == "") tag = "R7";
        end else if (code == 12'h040 || code == 12'h060) begin
          ePc = vbr + 32'h400;
          if (tag == "") tag = "R8";
        end else begin
          ePc = vbr + 32'h100;
          if (tag == "") tag = (code == 12'h160) ? "R9" : (bl ? "R3" : (ds ? "R6" : "R8"));
        end
      end
    end else if (irq && !ds && (!bl || slp) && vv) begin
      eTaken = 1'b1;
      eSsr = sr; eSgr = r15; eSpc = pc; eSr = sr | 32'h7000_0000;
      eInt = vec; ePc = vbr + 32'h600;
      if (tag == "") tag = bl ? "R4" : "R10";
    end else if (tag == "") begin
      tag = ds ? "R11" : (bl ? "R4" : "R10");
    end
    @(negedge clk);
    checkState(tag, eTaken, eRst, eDs);
    excValid = 1'b0; irqReq = 1'b0; irqVecValid = 1'b0;
    @(negedge clk);
    checkState("R12", 1'b0, 1'b0, 1'b0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nFail++;
      nTests++;
      $display("FAIL R12 watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    checkState("R12", 1'b0, 1'b0, 1'b0);

    // exception sweep: every code step of 0x20 up to 0x820, with delay slot and block bit
    for (int i = 0; i < 66; i++) begin
      for (int m = 0; m < 4; m++) begin
        logic [31:0] sr;
        logic [31:0] pc;
        sr = 32'h0000_80A0 | (32'(i) << 16);
        sr[28] = m[1];
        pc = 32'h0C00_1000 + 32'(i) * 4 + 32'(m) * 32'h100;
        request(1'b1, 12'(i * 32), 1'b0, 1'b0, 12'h000, sr, pc, ~pc,
                32'h8C00_0000 + 32'(i) * 32'h1000, m[0], 1'b0, "");
      end
    end

    // interrupt sweep: every mask with delay slot, block bit, sleep, vector presence
    for (int mask = 0; mask < 16; mask++) begin
      for (int k = 0; k < 16; k++) begin
        logic [31:0] sr;
        sr = 32'(mask) << 4;
        sr[28] = k[1];
        request(1'b0, 12'h000, 1'b1, k[3], 12'(12'h200 + mask * 32), sr,
                32'h0C80_0000 + 32'(k) * 8, 32'h7F00_0000 + 32'(mask),
                32'h8C10_0000 + 32'(mask) * 32'h40, k[0], k[2], "");
      end
    end

    // exception and interrupt in the same cycle: R1
    request(1'b1, 12'h0A0, 1'b1, 1'b1, 12'h3C0, 32'h0000_00F0, 32'h0C00_2000,
            32'h1234_5678, 32'h8000_0000, 1'b0, 1'b0, "R1");
    request(1'b1, 12'h040, 1'b1, 1'b1, 12'h320, 32'h0000_0010, 32'h0C00_3000,
            32'h2222_0000, 32'h8100_0000, 1'b0, 1'b0, "R1");
    request(1'b1, 12'h160, 1'b1, 1'b1, 12'h340, 32'h0000_0020, 32'h0C00_4000,
            32'h3333_0000, 32'h8200_0000, 1'b1, 1'b0, "R1");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule